// File: doc/BRIEF.md
# Repeated Signal-Unit Filter

This block sits behind a signalling-link receiver and decides, frame by frame, whether a received signal unit is handed on to software or silently dropped. The receiver presents one frame per cycle on a valid strobe. With the strobe it gives the first five header octets, the frame length in octets and a single flag that is set when the frame has any reception error. Fill-in and link-status units repeat back to back on an idle link. The filter lets the first copy and two identical repeats through, and drops every further identical copy until something changes.

The comparison covers three, four or five header octets. The count is taken from the length-indicator value carried in the current frame. Both the current octets and the stored octets of the previous frame are ANDed with a programmable five-octet mask before they are compared. Frames too short to be a signal unit are rejected before filtering. A separate pulse output counts every error-free frame, including the duplicates the filter drops, so that an error monitor elsewhere stays accurate. A software command re-arms the filter so that the following frame is always seen, and an enable input turns filtering off.

Top module: `su_repeat_filter`

## Requirements
- R1: Each cycle with `fr_valid` high produces, exactly one clock later, `dec_valid` high together with exactly one of `dec_deliver`, `dec_drop_dup` or `dec_drop_short`. A cycle without `fr_valid` produces all decision outputs low one clock later, and all outputs are low during and right after reset.
- R2: A frame with `fr_len` below 5 gives `dec_drop_short` without `efsu_inc`. It changes neither the repeat count nor the stored previous header.
- R3: The length indicator is bits [5:0] of octet 3 (`fr_hdr[21:16]`). Only values 0, 1 and 2 are filtered, and they compare octets 1–3, 1–4 and 1–5 respectively. Octets beyond that range have no effect on the match.
- R4: Octet k (k = 1..5) sits at `fr_hdr[8k-1:8k-8]`. Its mask is `cfg_mask_lo[8k-1:8k-8]` for k = 1..4 and `cfg_mask_hi[7:0]` for k = 5. A bit whose mask bit is 0 is ignored in the comparison.
- R5: The repeat count moves from 0 to 1 to 2 on successive matching, error-free, filterable frames, and each of these frames is delivered. A matching frame that arrives while the count is 2 gives `dec_drop_dup`, and the count stays at 2.
- R6: A filterable, error-free frame that does not match is delivered and returns the count to 0.
- R7: A frame with `fr_err` set (and length at least 5) is always delivered, gives no `efsu_inc`, and returns the count to 0.
- R8: A frame whose length indicator is above 2 is delivered and returns the count to 0.
- R9: While `cfg_filt_en` is low every frame of length at least 5 is delivered, and the count returns to 0.
- R10: A `cmd_rearm` pulse sets the count to 0. If a frame arrives in the same cycle, the re-arm takes effect before that frame is judged.
- R11: `efsu_inc` pulses with the decision of every error-free frame of length at least 5, whether it is delivered or dropped as a duplicate.
- R12: Every frame of length at least 5, dropped or not, replaces the stored previous header with its own unmasked octets. The first such frame after reset has no predecessor and never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_filt_en | input | 1 | Filtering enable; low delivers every frame |
| cfg_mask_lo | input | 32 | Compare mask for header octets 1–4, octet 1 in the low byte |
| cfg_mask_hi | input | 8 | Compare mask for header octet 5 |
| cmd_rearm | input | 1 | One-cycle pulse that returns the repeat count to 0 |
| fr_valid | input | 1 | A received frame is presented this cycle |
| fr_hdr | input | 40 | First five header octets, octet 1 in bits [7:0] |
| fr_len | input | 9 | Frame length in octets, flags excluded |
| fr_err | input | 1 | Frame carries a reception error |
| dec_valid | output | 1 | A decision is presented this cycle |
| dec_deliver | output | 1 | Frame is to be handed on |
| dec_drop_dup | output | 1 | Frame dropped as a repeated duplicate |
| dec_drop_short | output | 1 | Frame dropped as too short |
| efsu_inc | output | 1 | Count one error-free signal unit |

## Verification
Every result appears exactly one clock after the frame or re-arm pulse that causes it, because all outputs, the repeat count and the stored header come from a single register stage. The bench drives inputs on the falling edge. On the next falling edge it compares all five outputs against a behavioural model that was updated with the same inputs, so the result of each frame is checked in the one cycle where it is due. Idle cycles are compared the same way, which also confirms that no stray decision appears.

// File: rtl/su_filt_pkg.sv
package su_filt_pkg;

    typedef enum logic [1:0] {
        RPT_FRESH = 2'd0,
        RPT_ONCE  = 2'd1,
        RPT_TWICE = 2'd2
    } rpt_state_e;

    typedef struct packed {
        logic valid;
        logic deliver;
        logic drop_dup;
        logic drop_short;
        logic efsu_inc;
    } su_verdict_t;

endpackage

// File: rtl/su_frame_classify.sv
module su_frame_classify #(
    parameter int HDR_OCTETS  = 5,
    parameter int LEN_W       = 9,
    parameter int LI_OCTET    = 2,
    parameter int LI_W        = 6,
    parameter int MIN_LEN     = 5,
    parameter int FILT_LI_MAX = 2,
    parameter int BASE_CMP    = 3,
    parameter int CNT_W       = $clog2(HDR_OCTETS + 1)
) (
    input  logic [8*HDR_OCTETS-1:0] hdr,
    input  logic [LEN_W-1:0]        len,
    input  logic                    err,
    input  logic                    filt_en,
    output logic                    is_short,
    output logic                    filterable,
    output logic [CNT_W-1:0]        cmp_len
);

    localparam int LI_LSB = 8 * LI_OCTET;

    logic [LI_W-1:0] li;

    always_comb begin
        li         = hdr[LI_LSB +: LI_W];
        is_short   = (len < LEN_W'(MIN_LEN));
        filterable = filt_en && !err && (li <= LI_W'(FILT_LI_MAX));
        if (li <= LI_W'(FILT_LI_MAX)) begin
            cmp_len = CNT_W'(BASE_CMP) + CNT_W'(li);
        end else begin
            cmp_len = CNT_W'(HDR_OCTETS);
        end
    end

endmodule

// File: rtl/su_hdr_compare.sv
module su_hdr_compare #(
    parameter int HDR_OCTETS = 5,
    parameter int CNT_W      = $clog2(HDR_OCTETS + 1)
) (
    input  logic [8*HDR_OCTETS-1:0] cur_hdr,
    input  logic [8*HDR_OCTETS-1:0] prev_hdr,
    input  logic                    prev_valid,
    input  logic [8*HDR_OCTETS-1:0] mask,
    input  logic [CNT_W-1:0]        cmp_len,
    output logic                    match
);

    logic [HDR_OCTETS-1:0] octet_ok;

    for (genvar i = 0; i < HDR_OCTETS; i++) begin : g_octet
        logic in_window;
        logic differs;
        always_comb begin
            in_window   = (CNT_W'(i) < cmp_len);
            differs     = |((cur_hdr[8*i +: 8] ^ prev_hdr[8*i +: 8]) & mask[8*i +: 8]);
            octet_ok[i] = !in_window || !differs;
        end
    end

    always_comb begin
        match = prev_valid && (&octet_ok);
    end

endmodule

// File: rtl/su_repeat_fsm.sv
module su_repeat_fsm
    import su_filt_pkg::*;
#(
    parameter int HDR_OCTETS = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fr_valid,
    input  logic [8*HDR_OCTETS-1:0] fr_hdr,
    input  logic                    fr_err,
    input  logic                    is_short,
    input  logic                    filterable,
    input  logic                    match,
    input  logic                    rearm,
    output logic [8*HDR_OCTETS-1:0] prev_hdr,
    output logic                    prev_valid,
    output su_verdict_t             verdict
);

    localparam int HDR_W = 8 * HDR_OCTETS;

    typedef struct packed {
        rpt_state_e       st;
        logic [HDR_W-1:0] prev;
        logic             pv;
        su_verdict_t      vd;
    } fsm_regs_t;

    fsm_regs_t  r_q;
    fsm_regs_t  r_d;
    rpt_state_e st_eff;

    always_comb begin
        r_d    = r_q;
        r_d.vd = '0;
        st_eff = rearm ? RPT_FRESH : r_q.st;
        r_d.st = st_eff;
        if (fr_valid) begin
            r_d.vd.valid = 1'b1;
            if (is_short) begin
                r_d.vd.drop_short = 1'b1;
            end else begin
                r_d.vd.efsu_inc = !fr_err;
                r_d.prev        = fr_hdr;
                r_d.pv          = 1'b1;
                if (!filterable || !match) begin
                    r_d.st         = RPT_FRESH;
                    r_d.vd.deliver = 1'b1;
                end else begin
                    unique case (st_eff)
                        RPT_FRESH: begin
                            r_d.st         = RPT_ONCE;
                            r_d.vd.deliver = 1'b1;
                        end
                        RPT_ONCE: begin
                            r_d.st         = RPT_TWICE;
                            r_d.vd.deliver = 1'b1;
                        end
                        default: begin
                            r_d.st          = RPT_TWICE;
                            r_d.vd.drop_dup = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= RPT_FRESH;
            r_q.prev <= '0;
            r_q.pv   <= 1'b0;
            r_q.vd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign prev_hdr   = r_q.prev;
    assign prev_valid = r_q.pv;
    assign verdict    = r_q.vd;

    // R5: the count never jumps straight from 0 to 2
    p_no_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == RPT_FRESH |=> r_q.st != RPT_TWICE);

    // R5: a duplicate drop needs the count already at 2
    p_drop_needs_twice_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && !rearm && r_q.st != RPT_TWICE) |=> !r_q.vd.drop_dup);

    // R10: re-arm without a frame leaves the count at 0
    p_rearm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !fr_valid) |=> r_q.st == RPT_FRESH);

    // R2: short frames touch neither count nor stored header
    p_short_keeps_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && is_short && !rearm) |=> ($stable(r_q.st) && $stable(r_q.prev)));

endmodule

// File: rtl/su_repeat_filter.sv
module su_repeat_filter
    import su_filt_pkg::*;
#(
    parameter int HDR_OCTETS  = 5,
    parameter int LEN_W       = 9,
    parameter int LI_OCTET    = 2,
    parameter int LI_W        = 6,
    parameter int MIN_LEN     = 5,
    parameter int FILT_LI_MAX = 2,
    parameter int BASE_CMP    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_filt_en,
    input  logic [31:0]                 cfg_mask_lo,
    input  logic [8*HDR_OCTETS-33:0]    cfg_mask_hi,
    input  logic                        cmd_rearm,
    input  logic                        fr_valid,
    input  logic [8*HDR_OCTETS-1:0]     fr_hdr,
    input  logic [LEN_W-1:0]            fr_len,
    input  logic                        fr_err,
    output logic                        dec_valid,
    output logic                        dec_deliver,
    output logic                        dec_drop_dup,
    output logic                        dec_drop_short,
    output logic                        efsu_inc
);

    localparam int HDR_W  = 8 * HDR_OCTETS;
    localparam int CNT_W  = $clog2(HDR_OCTETS + 1);
    localparam int LI_LSB = 8 * LI_OCTET;

    logic             is_short;
    logic             filterable;
    logic [CNT_W-1:0] cmp_len;
    logic [HDR_W-1:0] prev_hdr;
    logic             prev_valid;
    logic             match;
    logic [HDR_W-1:0] mask_all;
    su_verdict_t      verdict;

    assign mask_all = {cfg_mask_hi, cfg_mask_lo};

    su_frame_classify #(
        .HDR_OCTETS (HDR_OCTETS),
        .LEN_W      (LEN_W),
        .LI_OCTET   (LI_OCTET),
        .LI_W       (LI_W),
        .MIN_LEN    (MIN_LEN),
        .FILT_LI_MAX(FILT_LI_MAX),
        .BASE_CMP   (BASE_CMP),
        .CNT_W      (CNT_W)
    ) u_classify (
        .hdr       (fr_hdr),
        .len       (fr_len),
        .err       (fr_err),
        .filt_en   (cfg_filt_en),
        .is_short  (is_short),
        .filterable(filterable),
        .cmp_len   (cmp_len)
    );

    su_hdr_compare #(
        .HDR_OCTETS(HDR_OCTETS),
        .CNT_W     (CNT_W)
    ) u_compare (
        .cur_hdr   (fr_hdr),
        .prev_hdr  (prev_hdr),
        .prev_valid(prev_valid),
        .mask      (mask_all),
        .cmp_len   (cmp_len),
        .match     (match)
    );

    su_repeat_fsm #(
        .HDR_OCTETS(HDR_OCTETS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fr_valid  (fr_valid),
        .fr_hdr    (fr_hdr),
        .fr_err    (fr_err),
        .is_short  (is_short),
        .filterable(filterable),
        .match     (match),
        .rearm     (cmd_rearm),
        .prev_hdr  (prev_hdr),
        .prev_valid(prev_valid),
        .verdict   (verdict)
    );

    assign dec_valid      = verdict.valid;
    assign dec_deliver    = verdict.deliver;
    assign dec_drop_dup   = verdict.drop_dup;
    assign dec_drop_short = verdict.drop_short;
    assign efsu_inc       = verdict.efsu_inc;

    // R1: a decision carries exactly one outcome
    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $onehot({dec_deliver, dec_drop_dup, dec_drop_short}));

    // R1: no decision without a frame one clock earlier
    p_no_stray_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_valid |=> !dec_valid);

    // R2: short frames are rejected and not counted
    p_short_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_len < LEN_W'(MIN_LEN)) |=> (dec_drop_short && !efsu_inc));

    // R7: errored frames always delivered, never counted
    p_err_delivered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_err && fr_len >= LEN_W'(MIN_LEN)) |=> (dec_deliver && !efsu_inc));

    // R8: longer length indicators bypass the filter
    p_msu_delivered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_len >= LEN_W'(MIN_LEN) && fr_hdr[LI_LSB +: LI_W] > LI_W'(FILT_LI_MAX))
        |=> dec_deliver);

    // R9: disabled filter delivers everything long enough
    p_disabled_delivers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && !cfg_filt_en && fr_len >= LEN_W'(MIN_LEN)) |=> dec_deliver);

    // R11: dropped duplicates are still counted as error-free
    p_dup_counted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_drop_dup |-> efsu_inc);

endmodule

// File: tb/tb_su_repeat_filter.sv
module tb_su_repeat_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_filt_en = 1'b1;
    logic [31:0] cfg_mask_lo = 32'hFFFF_FFFF;
    logic [7:0]  cfg_mask_hi = 8'hFF;
    logic        cmd_rearm = 1'b0;
    logic        fr_valid = 1'b0;
    logic [39:0] fr_hdr = '0;
    logic [8:0]  fr_len = '0;
    logic        fr_err = 1'b0;
    logic        dec_valid, dec_deliver, dec_drop_dup, dec_drop_short, efsu_inc;

    su_repeat_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_filt_en(cfg_filt_en),
        .cfg_mask_lo(cfg_mask_lo), .cfg_mask_hi(cfg_mask_hi),
        .cmd_rearm(cmd_rearm), .fr_valid(fr_valid), .fr_hdr(fr_hdr),
        .fr_len(fr_len), .fr_err(fr_err), .dec_valid(dec_valid),
        .dec_deliver(dec_deliver), .dec_drop_dup(dec_drop_dup),
        .dec_drop_short(dec_drop_short), .efsu_inc(efsu_inc)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // reference model state
    int          m_st = 0;
    logic [39:0] m_prev = '0;
    bit          m_pv = 0;
    logic [4:0]  exp_out = '0;   // {valid, deliver, drop_dup, drop_short, efsu}
    string       exp_tag = "R1";

    // pending stimulus applied by the next step
    bit          n_rearm = 0;
    bit          n_en = 1;
    logic [39:0] n_mask = 40'hFF_FFFF_FFFF;

    task automatic model_step(input bit v, input logic [39:0] h, input int len,
                              input bit e, input bit rr, input string tag);
        int  li;
        bit  same;
        exp_out = '0;
        exp_tag = tag;
        if (rr) m_st = 0;
        if (v) begin
            exp_out[4] = 1'b1;
            if (len < 5) begin
                exp_out[1] = 1'b1;
            end else begin
                exp_out[0] = !e;
                li = int'(h[21:16]);
                if (e || !n_en || li > 2) begin
                    m_st = 0;
                    exp_out[3] = 1'b1;
                end else begin
                    same = m_pv;
                    for (int i = 0; i < 3 + li; i++)
                        if (((h[8*i +: 8] ^ m_prev[8*i +: 8]) & n_mask[8*i +: 8]) != 8'h00)
                            same = 0;
                    if (!same) begin
                        m_st = 0;
                        exp_out[3] = 1'b1;
                    end else if (m_st == 2) begin
                        exp_out[2] = 1'b1;
                    end else begin
                        m_st = m_st + 1;
                        exp_out[3] = 1'b1;
                    end
                end
                m_prev = h;
                m_pv   = 1;
            end
        end
    endtask

    task automatic step(input bit v, input logic [39:0] h, input int len,
                        input bit e, input string tag);
        logic [4:0] act;
        @(negedge clk);
        act = {dec_valid, dec_deliver, dec_drop_dup, dec_drop_short, efsu_inc};
        checks++;
        if (act !== exp_out) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (valid,deliver,dup,short,efsu)",
                     exp_tag, act, exp_out);
        end
        fr_valid    = v;
        fr_hdr      = h;
        fr_len      = 9'(len);
        fr_err      = e;
        cmd_rearm   = n_rearm;
        cfg_filt_en = n_en;
        cfg_mask_lo = n_mask[31:0];
        cfg_mask_hi = n_mask[39:32];
        if (rst_n) model_step(v, h, len, e, n_rearm, tag);
        n_rearm = 0;
    endtask

    task automatic frm(input logic [7:0] o1, o2, o3, o4, o5, input int len,
                       input bit e, input string tag);
        step(1'b1, {o5, o4, o3, o2, o1}, len, e, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, 0, 1'b0, tag);
    endtask

    initial begin
        #(4 * 50000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R5 and R11: first copy plus two repeats delivered, then drops counted
        for (int k = 0; k < 3; k++) frm(8'h11, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R5");
        frm(8'h11, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R5");
        frm(8'h11, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R11");
        idle(1, "R1");

        // R6: mismatch in state 2 restarts the count
        frm(8'h12, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R6");
        for (int k = 0; k < 3; k++) frm(8'h12, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R6");

        // R2: a short frame between repeats changes nothing
        frm(8'h99, 8'h98, 8'h00, 8'h97, 8'h96, 4, 0, "R2");
        frm(8'h12, 8'h22, 8'h00, 8'hAA, 8'hBB, 5, 0, "R2");
        frm(8'h12, 8'h22, 8'h00, 8'hAA, 8'hBB, 0, 1, "R2");

        // R3: LI=0 ignores octets 4 and 5
        frm(8'h01, 8'h02, 8'h00, 8'h09, 8'h09, 5, 0, "R3");
        frm(8'h01, 8'h02, 8'h00, 8'h07, 8'h07, 5, 0, "R3");
        frm(8'h01, 8'h02, 8'h00, 8'h09, 8'h09, 5, 0, "R3");
        frm(8'h01, 8'h02, 8'h00, 8'h07, 8'h07, 5, 0, "R3");
        // R3: LI=1 compares octet 4 but not octet 5
        frm(8'h01, 8'h02, 8'h01, 8'h05, 8'h00, 6, 0, "R3");
        frm(8'h01, 8'h02, 8'h01, 8'h06, 8'h00, 6, 0, "R3");
        frm(8'h01, 8'h02, 8'h01, 8'h05, 8'h03, 6, 0, "R3");
        frm(8'h01, 8'h02, 8'h01, 8'h05, 8'h04, 6, 0, "R3");
        frm(8'h01, 8'h02, 8'h01, 8'h05, 8'h05, 6, 0, "R3");
        // R3: LI=2 compares octet 5
        frm(8'h01, 8'h02, 8'h02, 8'h05, 8'h01, 7, 0, "R3");
        frm(8'h01, 8'h02, 8'h02, 8'h05, 8'h02, 7, 0, "R3");

        // R4: octet 1 masked out
        n_mask = 40'hFF_FFFF_FF00;
        for (int k = 1; k <= 4; k++) frm(8'(k), 8'h33, 8'h00, 8'h00, 8'h00, 5, 0, "R4");
        // R12: the dropped frame (octet1=4) became the stored header
        n_mask = 40'hFF_FFFF_FFFF;
        frm(8'h04, 8'h33, 8'h00, 8'h00, 8'h00, 5, 0, "R12");
        frm(8'h03, 8'h33, 8'h00, 8'h00, 8'h00, 5, 0, "R12");
        // R4: octet 5 mask taken from the high mask byte
        n_mask = 40'h00_FFFF_FFFF;
        for (int k = 1; k <= 4; k++) frm(8'h44, 8'h55, 8'h02, 8'h66, 8'(k), 7, 0, "R4");
        n_mask = 40'hFF_FFFF_FFFF;

        // R7: errored frame delivered, not counted, count restarted
        for (int k = 0; k < 3; k++) frm(8'h21, 8'h43, 8'h00, 8'h00, 8'h00, 5, 0, "R7");
        frm(8'h21, 8'h43, 8'h00, 8'h00, 8'h00, 5, 1, "R7");
        frm(8'h21, 8'h43, 8'h00, 8'h00, 8'h00, 5, 0, "R7");
        frm(8'h21, 8'h43, 8'h00, 8'h00, 8'h00, 5, 0, "R7");
        frm(8'h21, 8'h43, 8'h00, 8'h00, 8'h00, 5, 0, "R7");

        // R8: message units (LI above 2) always delivered
        for (int k = 0; k < 4; k++) frm(8'h21, 8'h43, 8'h05, 8'h10, 8'h20, 10, 0, "R8");
        frm(8'h21, 8'h43, 8'h3F, 8'h10, 8'h20, 66, 0, "R8");

        // R9: disabled filter delivers all
        n_en = 0;
        for (int k = 0; k < 4; k++) frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R9");
        n_en = 1;
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R9");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R9");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R9");

        // R10: re-arm alone, then re-arm together with a frame
        n_rearm = 1;
        idle(1, "R10");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R10");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R10");
        n_rearm = 1;
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R10");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R10");
        frm(8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 5, 0, "R10");
        idle(3, "R1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule